// File: doc/BRIEF.md
# Configurable Tile Register File

This block holds eight two-dimensional tile registers for a matrix engine. Each tile has up to 16 rows of 64 bytes. A packed 64-byte configuration image sets the active layout, and that layout includes a row count and a byte width for each tile. Every access is checked against that shape. An access outside the shape is rejected and raises a one-cycle error. Read data is always trimmed to the configured row width. Before any configuration has been loaded, the block is in its initial state: palette 0, all shapes zero, all data zero. In that state every tile access is refused.

A memory-side agent uses the block through several ports:
- It loads and reads back the configuration image.
- It moves single rows in and out through a row load port and a row store port.
- It can clear one tile with the zero command.
- It can return the whole block to the initial state with the release command.

A compute unit has two read ports, A and B, which can be used in the same cycle. It returns results through a row write port. All row reads return data one cycle after the request. A loaded configuration, valid or not, and a release both clear every tile.

Simultaneous events are resolved by fixed priority. Release beats configuration load. Either of those beats any data write in the same cycle. Zeroing a tile beats a row write into that tile. Reads in the same cycle as a write see the contents from before the write.

Top module: `tile_regfile`

## Requirements
- R1: After reset, `cfg_image_o` is all zero, `err_o` is low, and all read valid and read data outputs are zero.
- R2: Loading a legal image makes `cfg_image_o` equal that image from the next cycle on. The image layout is as follows. Byte k occupies bits 8k+7..8k. Byte 0 is the palette. Bytes 16+2t (low) and 17+2t (high) hold the bytes-per-row of tile t. Byte 48+t holds the row count of tile t. All other bytes are reserved. A legal image has palette 1, every row count at most 16, every bytes-per-row at most 64, and all reserved bytes zero. An image with palette 0 returns the block to the initial state without an error.
- R3: Loading an image whose palette is neither 0 nor 1 is an error. So is a palette-1 image with a row count above 16, a bytes-per-row above 64, or a nonzero reserved byte. In each case `err_o` is high the next cycle and the configuration is all zero.
- R4: A store request returns the addressed row on `st_data_o` one cycle later, with `st_valid_o` high. Bytes at index ≥ the tile's bytes-per-row read as zero.
- R5: A row load at a row index ≥ the tile's row count leaves the tile unchanged and raises `err_o`. A store or compute read at such a row returns all zero and raises `err_o`.
- R6: While the palette is 0, every row load, store, compute read, compute write and zero command is refused with `err_o`.
- R7: The zero command clears all rows of the selected tile and no others.
- R8: Release sets the configuration to all zero and clears all tile data.
- R9: Any configuration load clears all tile data.
- R10: Compute read ports A and B serve two independent requests in the same cycle. Each has one-cycle latency, the R4 masking and the R5 bound check.
- R11: The compute write port stores a full row. When the row load port and the compute write port hit the same row in the same cycle, the row load data is kept.
- R12: `err_o` is high exactly in the cycle after a rejected operation and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Load configuration image |
| cfg_image_i | input | 512 | Configuration image to load |
| cfg_image_o | output | 512 | Current configuration, packed as an image |
| release_i | input | 1 | Return to initial state |
| zero_i | input | 1 | Zero-tile command |
| zero_tile_i | input | 3 | Tile to zero |
| ld_valid_i | input | 1 | Row load request |
| ld_tile_i | input | 3 | Row load tile |
| ld_row_i | input | 4 | Row load row index |
| ld_data_i | input | 512 | Row load data |
| st_req_i | input | 1 | Row store request |
| st_tile_i | input | 3 | Row store tile |
| st_row_i | input | 4 | Row store row index |
| st_valid_o | output | 1 | Row store data valid |
| st_data_o | output | 512 | Row store data |
| ra_req_i | input | 1 | Compute read A request |
| ra_tile_i | input | 3 | Compute read A tile |
| ra_row_i | input | 4 | Compute read A row |
| ra_valid_o | output | 1 | Compute read A valid |
| ra_data_o | output | 512 | Compute read A data |
| rb_req_i | input | 1 | Compute read B request |
| rb_tile_i | input | 3 | Compute read B tile |
| rb_row_i | input | 4 | Compute read B row |
| rb_valid_o | output | 1 | Compute read B valid |
| rb_data_o | output | 512 | Compute read B data |
| wr_valid_i | input | 1 | Compute write request |
| wr_tile_i | input | 3 | Compute write tile |
| wr_row_i | input | 4 | Compute write row |
| wr_data_i | input | 512 | Compute write data |
| err_o | output | 1 | Rejected-operation indication |

## Verification
Configuration faults show up on `cfg_image_o` in the cycle after the load or release that caused them. Examples are a shape decoded into the wrong field, a check that is skipped, or a clear that never happens. Faults in storage and bounds are hidden until a row is read. The bench therefore reads rows back right after every load, write and zero, and on both compute ports. A wrong mask, a missed write or a stale tile then becomes a data miscompare one cycle after the read request. A wrong bound decision also changes `err_o` in that same cycle.

// File: rtl/tile_rf_pkg.sv
package tile_rf_pkg;

    localparam int NUM_TILES = 8;
    localparam int MAX_ROWS  = 16;
    localparam int ROW_BYTES = 64;
    localparam int CFG_BYTES = 64;
    localparam int TILE_W    = $clog2(NUM_TILES);
    localparam int ROW_W     = $clog2(MAX_ROWS);
    localparam int ROW_BITS  = ROW_BYTES * 8;
    localparam int CFG_BITS  = CFG_BYTES * 8;
    localparam int BPR_W     = 16;
    localparam int CNT_W     = 8;

    // byte positions inside the packed configuration image
    localparam int PAL_BYTE  = 0;
    localparam int BPR_BASE  = 16;
    localparam int ROWS_BASE = 48;

    localparam logic [7:0] PAL_INIT    = 8'd0;
    localparam logic [7:0] PAL_8X16X64 = 8'd1;

    typedef struct packed {
        logic [CNT_W-1:0] rows;
        logic [BPR_W-1:0] bpr;
    } tile_shape_t;

    typedef struct packed {
        logic [7:0]                  palette;
        tile_shape_t [NUM_TILES-1:0] shape;
    } tile_cfg_t;

    typedef struct packed {
        logic              en;
        logic [TILE_W-1:0] tile;
        logic [ROW_W-1:0]  row;
    } row_ref_t;

    typedef struct packed {
        logic                en;
        logic [TILE_W-1:0]   tile;
        logic [ROW_W-1:0]    row;
        logic [ROW_BITS-1:0] data;
    } row_wr_t;

    function automatic logic cfg_byte_reserved(int k);
        return !((k == PAL_BYTE) ||
                 (k >= BPR_BASE  && k < BPR_BASE + 2 * NUM_TILES) ||
                 (k >= ROWS_BASE && k < ROWS_BASE + NUM_TILES));
    endfunction

    function automatic logic cfg_image_legal(logic [CFG_BITS-1:0] img);
        logic ok = (img[PAL_BYTE*8 +: 8] == PAL_8X16X64);
        for (int t = 0; t < NUM_TILES; t++) begin
            if (32'(img[(ROWS_BASE + t)*8 +: CNT_W]) > MAX_ROWS)     ok = 1'b0;
            if (32'(img[(BPR_BASE + 2*t)*8 +: BPR_W]) > ROW_BYTES)   ok = 1'b0;
        end
        for (int k = 0; k < CFG_BYTES; k++) begin
            if (cfg_byte_reserved(k) && img[k*8 +: 8] != 8'h00) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic tile_cfg_t cfg_unpack(logic [CFG_BITS-1:0] img);
        tile_cfg_t c;
        c.palette = img[PAL_BYTE*8 +: 8];
        for (int t = 0; t < NUM_TILES; t++) begin
            c.shape[t].bpr  = img[(BPR_BASE + 2*t)*8 +: BPR_W];
            c.shape[t].rows = img[(ROWS_BASE + t)*8 +: CNT_W];
        end
        return c;
    endfunction

    function automatic logic [CFG_BITS-1:0] cfg_pack(tile_cfg_t c);
        logic [CFG_BITS-1:0] img = '0;
        img[PAL_BYTE*8 +: 8] = c.palette;
        for (int t = 0; t < NUM_TILES; t++) begin
            img[(BPR_BASE + 2*t)*8 +: BPR_W] = c.shape[t].bpr;
            img[(ROWS_BASE + t)*8 +: CNT_W]  = c.shape[t].rows;
        end
        return img;
    endfunction

    function automatic logic [ROW_BITS-1:0] row_mask(logic [BPR_W-1:0] bpr);
        logic [ROW_BITS-1:0] m;
        for (int i = 0; i < ROW_BYTES; i++) begin
            m[i*8 +: 8] = (32'(bpr) > i) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

    function automatic logic row_in_bounds(tile_cfg_t c, logic [TILE_W-1:0] tile,
                                           logic [ROW_W-1:0] row);
        return (c.palette == PAL_8X16X64) && (CNT_W'(row) < c.shape[tile].rows);
    endfunction

endpackage

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit
    import tile_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                release_i,
    input  logic                load_i,
    input  logic [CFG_BITS-1:0] image_i,
    output tile_cfg_t           cfg_o,
    output logic [CFG_BITS-1:0] image_o,
    output logic                load_bad_o
);
    logic [7:0] pal_in;
    logic       img_ok;
    tile_cfg_t  cfg_q;

    assign pal_in     = image_i[PAL_BYTE*8 +: 8];
    assign img_ok     = cfg_image_legal(image_i);
    // palette 0 is a request for the initial state, not an error
    assign load_bad_o = load_i && (pal_in != PAL_INIT) && !img_ok;

    always_ff @(posedge clk) begin
        if (rst || release_i) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= img_ok ? cfg_unpack(image_i) : '0;
        end
    end

    assign cfg_o   = cfg_q;
    assign image_o = cfg_pack(cfg_q);
endmodule

// File: rtl/tile_row_store.sv
module tile_row_store
    import tile_rf_pkg::*;
#(
    parameter int NUM_WR = 2,
    parameter int NUM_RD = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clear_i,
    input  logic                             zero_i,
    input  logic [TILE_W-1:0]                zero_tile_i,
    input  row_wr_t  [NUM_WR-1:0]            wr_i,
    input  row_ref_t [NUM_RD-1:0]            rd_i,
    output logic     [NUM_RD-1:0][ROW_BITS-1:0] rd_data_o
);
    localparam int DEPTH = NUM_TILES * MAX_ROWS;

    logic [ROW_BITS-1:0] rows_flat [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        localparam logic [TILE_W-1:0] E_TILE = TILE_W'(e / MAX_ROWS);
        localparam logic [ROW_W-1:0]  E_ROW  = ROW_W'(e % MAX_ROWS);

        logic [ROW_BITS-1:0] row_q;
        logic [ROW_BITS-1:0] row_nxt;

        always_comb begin
            row_nxt = row_q;
            // port 0 is visited last so it wins a same-row collision
            for (int p = NUM_WR - 1; p >= 0; p--) begin
                if (wr_i[p].en && wr_i[p].tile == E_TILE && wr_i[p].row == E_ROW) begin
                    row_nxt = wr_i[p].data;
                end
            end
            if (zero_i && zero_tile_i == E_TILE) begin
                row_nxt = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clear_i) row_q <= '0;
            else                row_q <= row_nxt;
        end

        assign rows_flat[e] = row_q;
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_data_o[r] = rows_flat[{rd_i[r].tile, rd_i[r].row}];
    end
endmodule

// File: rtl/tile_read_port.sv
module tile_read_port
    import tile_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  row_ref_t            req_i,
    input  tile_cfg_t           cfg_i,
    input  logic [ROW_BITS-1:0] raw_i,
    output logic [ROW_BITS-1:0] data_o,
    output logic                valid_o,
    output logic                err_o
);
    logic                ok;
    logic [ROW_BITS-1:0] trimmed;

    assign ok      = row_in_bounds(cfg_i, req_i.tile, req_i.row);
    assign trimmed = raw_i & row_mask(cfg_i.shape[req_i.tile].bpr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= req_i.en;
            err_o   <= req_i.en && !ok;
            if (req_i.en) data_o <= ok ? trimmed : '0;
        end
    end
endmodule

// File: rtl/tile_regfile.sv
module tile_regfile
    import tile_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load_i,
    input  logic [CFG_BITS-1:0] cfg_image_i,
    output logic [CFG_BITS-1:0] cfg_image_o,
    input  logic                release_i,
    input  logic                zero_i,
    input  logic [TILE_W-1:0]   zero_tile_i,
    input  logic                ld_valid_i,
    input  logic [TILE_W-1:0]   ld_tile_i,
    input  logic [ROW_W-1:0]    ld_row_i,
    input  logic [ROW_BITS-1:0] ld_data_i,
    input  logic                st_req_i,
    input  logic [TILE_W-1:0]   st_tile_i,
    input  logic [ROW_W-1:0]    st_row_i,
    output logic                st_valid_o,
    output logic [ROW_BITS-1:0] st_data_o,
    input  logic                ra_req_i,
    input  logic [TILE_W-1:0]   ra_tile_i,
    input  logic [ROW_W-1:0]    ra_row_i,
    output logic                ra_valid_o,
    output logic [ROW_BITS-1:0] ra_data_o,
    input  logic                rb_req_i,
    input  logic [TILE_W-1:0]   rb_tile_i,
    input  logic [ROW_W-1:0]    rb_row_i,
    output logic                rb_valid_o,
    output logic [ROW_BITS-1:0] rb_data_o,
    input  logic                wr_valid_i,
    input  logic [TILE_W-1:0]   wr_tile_i,
    input  logic [ROW_W-1:0]    wr_row_i,
    input  logic [ROW_BITS-1:0] wr_data_i,
    output logic                err_o
);
    localparam int NUM_WR = 2;   // 0: row load (wins), 1: compute write
    localparam int NUM_RD = 3;   // 0: row store, 1: compute A, 2: compute B

    tile_cfg_t cfg;
    logic      cfg_bad;
    logic      clear_all;
    logic      ld_ok, wr_ok, zero_ok;
    logic      err_q;

    row_wr_t  [NUM_WR-1:0]               wr_req;
    row_ref_t [NUM_RD-1:0]               rd_req;
    logic     [NUM_RD-1:0][ROW_BITS-1:0] raw;
    logic     [NUM_RD-1:0][ROW_BITS-1:0] rd_data;
    logic     [NUM_RD-1:0]               rd_valid;
    logic     [NUM_RD-1:0]               rd_err;

    tile_cfg_unit u_cfg (
        .clk        (clk),
        .rst        (rst),
        .release_i  (release_i),
        .load_i     (cfg_load_i),
        .image_i    (cfg_image_i),
        .cfg_o      (cfg),
        .image_o    (cfg_image_o),
        .load_bad_o (cfg_bad)
    );

    assign clear_all = release_i | cfg_load_i;
    assign ld_ok     = row_in_bounds(cfg, ld_tile_i, ld_row_i);
    assign wr_ok     = row_in_bounds(cfg, wr_tile_i, wr_row_i);
    assign zero_ok   = (cfg.palette == PAL_8X16X64);

    always_comb begin
        wr_req[0].en   = ld_valid_i && ld_ok;
        wr_req[0].tile = ld_tile_i;
        wr_req[0].row  = ld_row_i;
        wr_req[0].data = ld_data_i;
        wr_req[1].en   = wr_valid_i && wr_ok;
        wr_req[1].tile = wr_tile_i;
        wr_req[1].row  = wr_row_i;
        wr_req[1].data = wr_data_i;

        rd_req[0].en   = st_req_i;
        rd_req[0].tile = st_tile_i;
        rd_req[0].row  = st_row_i;
        rd_req[1].en   = ra_req_i;
        rd_req[1].tile = ra_tile_i;
        rd_req[1].row  = ra_row_i;
        rd_req[2].en   = rb_req_i;
        rd_req[2].tile = rb_tile_i;
        rd_req[2].row  = rb_row_i;
    end

    tile_row_store #(
        .NUM_WR (NUM_WR),
        .NUM_RD (NUM_RD)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear_all),
        .zero_i      (zero_i && zero_ok),
        .zero_tile_i (zero_tile_i),
        .wr_i        (wr_req),
        .rd_i        (rd_req),
        .rd_data_o   (raw)
    );

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        tile_read_port u_port (
            .clk     (clk),
            .rst     (rst),
            .req_i   (rd_req[r]),
            .cfg_i   (cfg),
            .raw_i   (raw[r]),
            .data_o  (rd_data[r]),
            .valid_o (rd_valid[r]),
            .err_o   (rd_err[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= cfg_bad
                   | (ld_valid_i && !ld_ok)
                   | (wr_valid_i && !wr_ok)
                   | (zero_i && !zero_ok);
        end
    end

    assign st_data_o  = rd_data[0];
    assign st_valid_o = rd_valid[0];
    assign ra_data_o  = rd_data[1];
    assign ra_valid_o = rd_valid[1];
    assign rb_data_o  = rd_data[2];
    assign rb_valid_o = rd_valid[2];
    assign err_o      = err_q | (|rd_err);
endmodule

// File: rtl/tile_regfile_chk.sv
module tile_regfile_chk
    import tile_rf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                release_i,
    input logic                cfg_load_i,
    input logic [CFG_BITS-1:0] cfg_image_i,
    input logic [CFG_BITS-1:0] cfg_image_o,
    input logic                ld_valid_i,
    input logic                st_req_i,
    input logic [TILE_W-1:0]   st_tile_i,
    input logic [ROW_W-1:0]    st_row_i,
    input logic                st_valid_o,
    input logic [ROW_BITS-1:0] st_data_o,
    input logic                ra_req_i,
    input logic                rb_req_i,
    input logic                wr_valid_i,
    input logic                zero_i,
    input logic                err_o
);
    logic [7:0] st_rows;
    assign st_rows = cfg_image_o[(ROWS_BASE + 32'(st_tile_i))*8 +: 8];

    assert_release_init_R8: assert property (@(posedge clk) disable iff (rst)
        release_i |=> (cfg_image_o == '0));

    assert_bad_palette_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_load_i && !release_i && cfg_image_i[7:0] > 8'd1) |=> (err_o && cfg_image_o == '0));

    assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_load_i && !release_i) |=>
            (cfg_image_o == $past(cfg_image_i)) || (cfg_image_o == '0));

    assert_init_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (ld_valid_i && cfg_image_o[7:0] == 8'd0) |=> err_o);

    assert_store_valid_R4: assert property (@(posedge clk) disable iff (rst)
        st_req_i |=> st_valid_o);

    assert_store_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !st_req_i |=> !st_valid_o);

    assert_oob_store_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (st_req_i && ({4'b0, st_row_i} >= st_rows)) |=> (st_data_o == '0 && err_o));

    assert_err_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load_i && !ld_valid_i && !st_req_i && !ra_req_i && !rb_req_i &&
         !wr_valid_i && !zero_i) |=> !err_o);
endmodule

bind tile_regfile tile_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .release_i   (release_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_image_i (cfg_image_i),
    .cfg_image_o (cfg_image_o),
    .ld_valid_i  (ld_valid_i),
    .st_req_i    (st_req_i),
    .st_tile_i   (st_tile_i),
    .st_row_i    (st_row_i),
    .st_valid_o  (st_valid_o),
    .st_data_o   (st_data_o),
    .ra_req_i    (ra_req_i),
    .rb_req_i    (rb_req_i),
    .wr_valid_i  (wr_valid_i),
    .zero_i      (zero_i),
    .err_o       (err_o)
);

// File: tb/tile_regfile_tb_top.sv
module tile_regfile_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_load_i;
    logic [511:0] cfg_image_i;
    logic [511:0] cfg_image_o;
    logic         release_i;
    logic         zero_i;
    logic [2:0]   zero_tile_i;
    logic         ld_valid_i;
    logic [2:0]   ld_tile_i;
    logic [3:0]   ld_row_i;
    logic [511:0] ld_data_i;
    logic         st_req_i;
    logic [2:0]   st_tile_i;
    logic [3:0]   st_row_i;
    logic         st_valid_o;
    logic [511:0] st_data_o;
    logic         ra_req_i;
    logic [2:0]   ra_tile_i;
    logic [3:0]   ra_row_i;
    logic         ra_valid_o;
    logic [511:0] ra_data_o;
    logic         rb_req_i;
    logic [2:0]   rb_tile_i;
    logic [3:0]   rb_row_i;
    logic         rb_valid_o;
    logic [511:0] rb_data_o;
    logic         wr_valid_i;
    logic [2:0]   wr_tile_i;
    logic [3:0]   wr_row_i;
    logic [511:0] wr_data_i;
    logic         err_o;

    always #4 clk = ~clk;   // 125 MHz

    tile_regfile dut_i (.*);

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    logic [511:0] m_mem [8][16];
    int           m_pal;
    int           m_rows [8];
    int           m_bpr  [8];
    logic [511:0] e_st, e_ra, e_rb;
    bit           e_stv, e_rav, e_rbv, e_err;

    int c_rows [8] = '{16, 4, 1, 0, 8, 16, 2, 3};
    int c_bpr  [8] = '{64, 10, 1, 0, 33, 64, 5, 64};

    function automatic logic [511:0] rand_row();
        logic [511:0] d;
        for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic logic [511:0] build_image(int pal);
        logic [511:0] img = '0;
        img[7:0] = pal[7:0];
        for (int t = 0; t < 8; t++) begin
            img[(16 + 2*t)*8 +: 16] = c_bpr[t][15:0];
            img[(48 + t)*8 +: 8]    = c_rows[t][7:0];
        end
        return img;
    endfunction

    function automatic logic [511:0] model_image();
        logic [511:0] img = '0;
        img[7:0] = m_pal[7:0];
        for (int t = 0; t < 8; t++) begin
            img[(16 + 2*t)*8 +: 16] = m_bpr[t][15:0];
            img[(48 + t)*8 +: 8]    = m_rows[t][7:0];
        end
        return img;
    endfunction

    function automatic bit image_ok(logic [511:0] img);
        if (img[7:0] != 8'd1) return 0;
        for (int t = 0; t < 8; t++) begin
            if (img[(48 + t)*8 +: 8] > 8'd16)       return 0;
            if (img[(16 + 2*t)*8 +: 16] > 16'd64)   return 0;
        end
        for (int k = 0; k < 64; k++) begin
            bit used = (k == 0) || (k >= 16 && k < 32) || (k >= 48 && k < 56);
            if (!used && img[k*8 +: 8] != 8'h00) return 0;
        end
        return 1;
    endfunction

    function automatic logic [511:0] trim(logic [511:0] d, int n);
        for (int i = 0; i < 64; i++) if (i >= n) d[i*8 +: 8] = 8'h00;
        return d;
    endfunction

    function automatic bit in_rng(int t, int r);
        return (m_pal == 1) && (r < m_rows[t]);
    endfunction

    task automatic model_clear();
        for (int t = 0; t < 8; t++) begin
            for (int r = 0; r < 16; r++) m_mem[t][r] = '0;
            m_rows[t] = 0;
            m_bpr[t]  = 0;
        end
        m_pal = 0;
    endtask

    task automatic idle();
        cfg_load_i = 0; cfg_image_i = '0; release_i = 0;
        zero_i = 0; zero_tile_i = 0;
        ld_valid_i = 0; ld_tile_i = 0; ld_row_i = 0; ld_data_i = '0;
        st_req_i = 0; st_tile_i = 0; st_row_i = 0;
        ra_req_i = 0; ra_tile_i = 0; ra_row_i = 0;
        rb_req_i = 0; rb_tile_i = 0; rb_row_i = 0;
        wr_valid_i = 0; wr_tile_i = 0; wr_row_i = 0; wr_data_i = '0;
    endtask

    task automatic model_step();
        bit cfg_good;
        e_err = 0;
        e_stv = st_req_i;
        if (st_req_i) begin
            if (in_rng(st_tile_i, st_row_i)) e_st = trim(m_mem[st_tile_i][st_row_i], m_bpr[st_tile_i]);
            else begin e_st = '0; e_err = 1; end
        end
        e_rav = ra_req_i;
        if (ra_req_i) begin
            if (in_rng(ra_tile_i, ra_row_i)) e_ra = trim(m_mem[ra_tile_i][ra_row_i], m_bpr[ra_tile_i]);
            else begin e_ra = '0; e_err = 1; end
        end
        e_rbv = rb_req_i;
        if (rb_req_i) begin
            if (in_rng(rb_tile_i, rb_row_i)) e_rb = trim(m_mem[rb_tile_i][rb_row_i], m_bpr[rb_tile_i]);
            else begin e_rb = '0; e_err = 1; end
        end
        if (ld_valid_i && !in_rng(ld_tile_i, ld_row_i)) e_err = 1;
        if (wr_valid_i && !in_rng(wr_tile_i, wr_row_i)) e_err = 1;
        if (zero_i && m_pal != 1) e_err = 1;
        cfg_good = image_ok(cfg_image_i);
        if (cfg_load_i && cfg_image_i[7:0] != 8'd0 && !cfg_good) e_err = 1;

        if (release_i) begin
            model_clear();
        end else if (cfg_load_i) begin
            model_clear();
            if (cfg_good) begin
                m_pal = 1;
                for (int t = 0; t < 8; t++) begin
                    m_rows[t] = int'(cfg_image_i[(48 + t)*8 +: 8]);
                    m_bpr[t]  = int'(cfg_image_i[(16 + 2*t)*8 +: 16]);
                end
            end
        end else begin
            if (wr_valid_i && in_rng(wr_tile_i, wr_row_i)) m_mem[wr_tile_i][wr_row_i] = wr_data_i;
            if (ld_valid_i && in_rng(ld_tile_i, ld_row_i)) m_mem[ld_tile_i][ld_row_i] = ld_data_i;
            if (zero_i && m_pal == 1)
                for (int r = 0; r < 16; r++) m_mem[zero_tile_i][r] = '0;
        end
    endtask

    task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // inputs are already set at a falling edge; compare after the next rising edge
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "cfg_image_o", cfg_image_o, model_image());
        chk(tag, "err_o",       {511'b0, err_o},      {511'b0, e_err});
        chk(tag, "st_valid_o",  {511'b0, st_valid_o}, {511'b0, e_stv});
        chk(tag, "st_data_o",   st_data_o, e_st);
        chk(tag, "ra_valid_o",  {511'b0, ra_valid_o}, {511'b0, e_rav});
        chk(tag, "ra_data_o",   ra_data_o, e_ra);
        chk(tag, "rb_valid_o",  {511'b0, rb_valid_o}, {511'b0, e_rbv});
        chk(tag, "rb_data_o",   rb_data_o, e_rb);
        idle();
    endtask

    task automatic do_ld(int t, int r, logic [511:0] d);
        ld_valid_i = 1; ld_tile_i = t[2:0]; ld_row_i = r[3:0]; ld_data_i = d;
    endtask
    task automatic do_st(int t, int r);
        st_req_i = 1; st_tile_i = t[2:0]; st_row_i = r[3:0];
    endtask
    task automatic do_wr(int t, int r, logic [511:0] d);
        wr_valid_i = 1; wr_tile_i = t[2:0]; wr_row_i = r[3:0]; wr_data_i = d;
    endtask
    task automatic do_cfg(logic [511:0] img);
        cfg_load_i = 1; cfg_image_i = img;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [511:0] img;
        logic [511:0] pat_a;
        logic [511:0] pat_b;
        idle();
        rst = 1;
        model_clear();
        e_st = '0; e_ra = '0; e_rb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        step("R1");

        // initial state: every tile access refused
        do_ld(0, 0, rand_row());         step("R6");
        do_st(0, 0);                     step("R6");
        zero_i = 1; zero_tile_i = 3'd1;  step("R6");
        ra_req_i = 1; rb_req_i = 1;      step("R6");
        do_wr(2, 0, rand_row());         step("R6");
        step("R12");

        // illegal images
        img = build_image(2);              do_cfg(img); step("R3");
        img = build_image(1); img[(48+2)*8 +: 8] = 8'd17;     do_cfg(img); step("R3");
        img = build_image(1); img[(16+8)*8 +: 16] = 16'd65;   do_cfg(img); step("R3");
        img = build_image(1); img[5*8 +: 8] = 8'h01;          do_cfg(img); step("R3");
        img = build_image(1); img[60*8 +: 8] = 8'h80;         do_cfg(img); step("R3");
        step("R12");

        // legal image and readback
        do_cfg(build_image(1));          step("R2");

        // row load / store with trimming
        pat_a = rand_row(); pat_b = rand_row();
        do_ld(0, 0, pat_a);              step("R4");
        do_ld(1, 3, pat_b);              step("R4");
        do_ld(2, 0, ~pat_a);             step("R4");
        do_st(0, 0);                     step("R4");
        do_st(1, 3);                     step("R4");
        do_st(2, 0);                     step("R4");

        // bounds
        do_ld(1, 4, rand_row());         step("R5");
        do_st(1, 3);                     step("R5");
        do_st(1, 5);                     step("R5");
        do_st(3, 0);                     step("R5");
        do_ld(7, 3, rand_row());         step("R5");
        do_ld(5, 15, pat_b);             step("R5");
        do_st(5, 15);                    step("R5");

        // dual compute reads
        ra_req_i = 1; ra_tile_i = 3'd0; ra_row_i = 4'd0;
        rb_req_i = 1; rb_tile_i = 3'd1; rb_row_i = 4'd3;  step("R10");
        ra_req_i = 1; ra_tile_i = 3'd6; ra_row_i = 4'd2;
        rb_req_i = 1; rb_tile_i = 3'd2; rb_row_i = 4'd0;  step("R10");

        // compute write and collision with row load
        do_wr(4, 7, pat_a);              step("R11");
        do_st(4, 7);                     step("R11");
        do_wr(5, 1, pat_a); do_ld(5, 1, pat_b);            step("R11");
        do_st(5, 1);                     step("R11");

        // zero one tile only
        do_ld(6, 1, pat_b);              step("R7");
        zero_i = 1; zero_tile_i = 3'd0;  step("R7");
        do_st(0, 0);                     step("R7");
        do_st(6, 1);                     step("R7");
        do_st(1, 3);                     step("R7");

        // mixed traffic
        for (int i = 0; i < 200; i++) begin
            case ($urandom % 6)
                0: do_ld($urandom % 8, $urandom % 16, rand_row());
                1: do_st($urandom % 8, $urandom % 16);
                2: begin
                    ra_req_i = 1; ra_tile_i = 3'($urandom % 8); ra_row_i = 4'($urandom % 16);
                    rb_req_i = 1; rb_tile_i = 3'($urandom % 8); rb_row_i = 4'($urandom % 16);
                end
                3: do_wr($urandom % 8, $urandom % 16, rand_row());
                4: begin
                    do_ld($urandom % 8, $urandom % 16, rand_row());
                    do_st($urandom % 8, $urandom % 16);
                end
                default: if (($urandom % 8) == 0) begin zero_i = 1; zero_tile_i = 3'($urandom % 8); end
            endcase
            step("R10");
        end

        // reload clears data
        do_ld(1, 2, pat_a);              step("R9");
        do_cfg(build_image(1));          step("R9");
        do_st(1, 2);                     step("R9");

        // release
        do_ld(4, 5, pat_b);              step("R8");
        release_i = 1;                   step("R8");
        do_ld(0, 0, pat_a);              step("R8");
        do_cfg(build_image(1));          step("R8");
        do_st(4, 5);                     step("R8");
        do_cfg(build_image(0));          step("R2");
        step("R12");

        finish_run();
    end
endmodule